// File: doc/BRIEF.md
# CDR Lock Supervisor and Output Steering

This block is the digital supervisor that sits beside a clock/data recovery loop. It measures how fast the local oscillator runs by counting its cycles across a fixed window of reference-clock cycles. It compares that count with the count the selected line rate calls for and keeps a lock-detect flag. The flag rises only when the frequency agrees within a tolerance given in ppm. It is held low whenever the signal-detect input or the track-enable input is low.

The flag then steers the outputs. While the loop is locked, the oscillator clock and the recovered data pass through. While it is unlocked, the data output pair is parked at a fixed level, and the clock output follows the reference clock. A test bypass input overrides the clock steering and sends out the inverted reference clock.

Inside the block, a three-state machine decides lock. The states are `ST_HUNT` (no good measurement yet), `ST_QUAL` (one good measurement seen) and `ST_LOCK` (locked). The transitions are:
- hunt-to-qualify on an in-tolerance measurement;
- qualify-to-lock on a second consecutive in-tolerance measurement;
- qualify-to-hunt on a miss;
- lock-to-hunt on any single miss.

The oscillator count crosses into the reference domain through a toggle request/acknowledge handshake.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While reset is asserted, `lock_ok` is 0, `dout_p` is 0 and `dout_n` is 1.
- R2: With both qualifiers high, an oscillator running at the expected ratio within ±PPM (default 500 ppm) leads `lock_ok` to go to 1.
- R3: A single measurement whose count is off by more than the tolerance returns the state machine to `ST_HUNT` and drops `lock_ok`. At +1500 ppm, `lock_ok` is 0 within two windows.
- R4: `lock_ok` rises only after two consecutive in-tolerance measurements. After reset, the first window only primes the count, so with a good oscillator `lock_ok` is still 0 at 2.5 windows and is 1 by 3.5 windows.
- R5: When `sig_present` falls, `lock_ok` is 0 after the third rising reference edge and is unaffected by it before that.
- R6: When `track_en` falls, `lock_ok` is 0 after the third rising reference edge.
- R7: Whenever `lock_ok` is 0, `dout_p` is 0 and `dout_n` is 1.
- R8: While `lock_ok` is 1 and `bypass` is 0, `dout_p` equals `rx_data`, `dout_n` is its complement, and `clk_out` follows `osc_clk`.
- R9: While `lock_ok` is 0 and `bypass` is 0, `clk_out` follows `ref_clk`.
- R10: `rate_hi` = 0 expects an oscillator/reference ratio of LOW_RATIO (default 8). `rate_hi` = 1 expects 4×LOW_RATIO (default 32). An oscillator at the other rate's ratio never locks.
- R11: With `bypass` = 1, `clk_out` is the inverse of `ref_clk` whatever the lock state.
- R12: The oscillator count reaches the reference domain only through the toggle handshake. A new request is raised only after the previous one is acknowledged, and each result lands early in the following window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; clocks the measurement window and the lock logic |
| osc_clk | input | 1 | Local oscillator / recovered clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sig_present | input | 1 | Signal detect; 0 means loss of signal |
| track_en | input | 1 | 0 forces the output to follow the reference |
| rate_hi | input | 1 | Line rate select: 0 low rate, 1 four times higher |
| bypass | input | 1 | Test bypass: clock output is inverted reference |
| rx_data | input | 1 | Recovered serial data |
| lock_ok | output | 1 | Lock detect flag (reference domain) |
| clk_out | output | 1 | Steered clock output |
| dout_p | output | 1 | True data output |
| dout_n | output | 1 | Complementary data output |

## Verification
Two things can land on the same reference edge. One is the state machine reporting lock from a good measurement. The other is a qualifier dropping, which must still force the flag low.

The bench provokes this by pulling `sig_present` and `track_en` low while the frequency is good and the machine sits in `ST_LOCK`. It then judges the flag edge by edge: still high after two edges, low after the third. It then checks that the flag returns without any new measurement once the qualifier comes back.

Bypass is likewise applied while the loop is locked. The bench checks that the clock output inverts the reference while the data path still reports lock.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_QUAL = 2'd1,
        ST_LOCK = 2'd2
    } lock_st_e;

    // Number of oscillator cycles expected over 2**win_log2 reference cycles
    function automatic longint exp_count(input int win_log2, input int ratio);
        return longint'(ratio) << win_log2;
    endfunction

    // Tolerance in counts for a given expected count and ppm limit
    function automatic longint tol_count(input longint expc, input int ppm);
        return (expc * ppm) / 1000000;
    endfunction

endpackage

// File: rtl/cdr_sync2.sv
module cdr_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/cdr_freq_meter.sv
module cdr_freq_meter #(
    parameter int WIN_LOG2 = 13,
    parameter int CNT_W    = 20
) (
    input  logic             ref_clk,
    input  logic             osc_clk,
    input  logic             rst_n,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_cnt
);

    // ---------------- reference domain ----------------
    logic [WIN_LOG2-1:0] win_cnt;
    logic                req_t;
    logic                ack_s;
    logic                ack_seen;
    logic                have_prev;
    logic [CNT_W-1:0]    prev_cap;

    // ---------------- oscillator domain ----------------
    logic [CNT_W-1:0]    osc_cnt;
    logic [CNT_W-1:0]    osc_hold;
    logic                req_s;
    logic                ack_t;

    logic win_end;
    assign win_end = &win_cnt;

    cdr_sync2 #(.W(1)) u_ack_sync (
        .clk  (ref_clk),
        .rst_n(rst_n),
        .d    (ack_t),
        .q    (ack_s)
    );

    cdr_sync2 #(.W(1)) u_req_sync (
        .clk  (osc_clk),
        .rst_n(rst_n),
        .d    (req_t),
        .q    (req_s)
    );

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt    <= '0;
            req_t      <= 1'b0;
            ack_seen   <= 1'b0;
            have_prev  <= 1'b0;
            prev_cap   <= '0;
            meas_valid <= 1'b0;
            meas_cnt   <= '0;
        end else begin
            win_cnt    <= win_cnt + 1'b1;
            meas_valid <= 1'b0;
            if (win_end && (ack_seen == req_t))
                req_t <= ~req_t;
            ack_seen <= ack_s;
            if (ack_s != ack_seen) begin
                // osc_hold has been stable since before ack_t toggled
                prev_cap   <= osc_hold;
                have_prev  <= 1'b1;
                meas_valid <= have_prev;
                meas_cnt   <= osc_hold - prev_cap;
            end
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_cnt  <= '0;
            osc_hold <= '0;
            ack_t    <= 1'b0;
        end else begin
            osc_cnt <= osc_cnt + 1'b1;
            if (req_s != ack_t) begin
                osc_hold <= osc_cnt;
                ack_t    <= req_s;
            end
        end
    end

    // A request toggles only once the previous one has been acknowledged
    p_req_idle_r12: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (req_t != $past(req_t)) |-> ($past(ack_seen) == $past(req_t)));

    // Results arrive shortly after the window boundary, never mid-window
    p_meas_early_r12: assert property (@(posedge ref_clk) disable iff (!rst_n)
        meas_valid |-> (win_cnt < 16));

endmodule

// File: rtl/cdr_lock_fsm.sv
module cdr_lock_fsm
    import cdr_lock_pkg::*;
#(
    parameter int WIN_LOG2  = 13,
    parameter int LOW_RATIO = 8,
    parameter int PPM       = 500,
    parameter int CNT_W     = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_hi,
    input  logic             sd_ok,
    input  logic             trk_ok,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_cnt,
    output logic             lock_ok
);

    localparam longint EXP_LO = exp_count(WIN_LOG2, LOW_RATIO);
    localparam longint EXP_HI = exp_count(WIN_LOG2, LOW_RATIO * 4);
    localparam longint TOL_LO = tol_count(EXP_LO, PPM);
    localparam longint TOL_HI = tol_count(EXP_HI, PPM);
    localparam logic [CNT_W:0] EXP_LO_V = (CNT_W+1)'(EXP_LO);
    localparam logic [CNT_W:0] EXP_HI_V = (CNT_W+1)'(EXP_HI);
    localparam logic [CNT_W:0] TOL_LO_V = (CNT_W+1)'(TOL_LO);
    localparam logic [CNT_W:0] TOL_HI_V = (CNT_W+1)'(TOL_HI);

    lock_st_e        state, state_nxt;
    logic [CNT_W:0]  exp_v, tol_v, delta, mag;
    logic            in_tol;

    always_comb begin
        exp_v  = rate_hi ? EXP_HI_V : EXP_LO_V;
        tol_v  = rate_hi ? TOL_HI_V : TOL_LO_V;
        delta  = {1'b0, meas_cnt} - exp_v;
        mag    = delta[CNT_W] ? (~delta + 1'b1) : delta;
        in_tol = (mag <= tol_v);
    end

    always_comb begin
        state_nxt = state;
        if (meas_valid) begin
            unique case (state)
                ST_HUNT: state_nxt = in_tol ? ST_QUAL : ST_HUNT;
                ST_QUAL: state_nxt = in_tol ? ST_LOCK : ST_HUNT;
                ST_LOCK: state_nxt = in_tol ? ST_LOCK : ST_HUNT;
                default: state_nxt = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nxt;
    end

    // Output register: lock qualified by both external conditions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_ok <= 1'b0;
        else        lock_ok <= (state == ST_LOCK) && sd_ok && trk_ok;
    end

    p_drop_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && !in_tol) |=> (state == ST_HUNT));

    p_hyst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LOCK) && ($past(state) != ST_LOCK)) |-> ($past(state) == ST_QUAL));

endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl #(
    parameter int WIN_LOG2  = 13,
    parameter int LOW_RATIO = 8,
    parameter int PPM       = 500
) (
    input  logic ref_clk,
    input  logic osc_clk,
    input  logic rst_n,
    input  logic sig_present,
    input  logic track_en,
    input  logic rate_hi,
    input  logic bypass,
    input  logic rx_data,
    output logic lock_ok,
    output logic clk_out,
    output logic dout_p,
    output logic dout_n
);

    localparam int CNT_W = WIN_LOG2 + $clog2(LOW_RATIO * 4) + 2;

    logic [2:0]       ctl_raw, ctl_s;
    logic             sd_s, trk_s, rate_s;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_cnt;

    assign ctl_raw = {rate_hi, track_en, sig_present};
    assign sd_s    = ctl_s[0];
    assign trk_s   = ctl_s[1];
    assign rate_s  = ctl_s[2];

    cdr_sync2 #(.W(3)) u_ctl_sync (
        .clk  (ref_clk),
        .rst_n(rst_n),
        .d    (ctl_raw),
        .q    (ctl_s)
    );

    cdr_freq_meter #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_meter (
        .ref_clk   (ref_clk),
        .osc_clk   (osc_clk),
        .rst_n     (rst_n),
        .meas_valid(meas_valid),
        .meas_cnt  (meas_cnt)
    );

    cdr_lock_fsm #(
        .WIN_LOG2 (WIN_LOG2),
        .LOW_RATIO(LOW_RATIO),
        .PPM      (PPM),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .rate_hi   (rate_s),
        .sd_ok     (sd_s),
        .trk_ok    (trk_s),
        .meas_valid(meas_valid),
        .meas_cnt  (meas_cnt),
        .lock_ok   (lock_ok)
    );

    // Output steering
    always_comb begin
        if (bypass)       clk_out = ~ref_clk;
        else if (lock_ok) clk_out = osc_clk;
        else              clk_out = ref_clk;
        dout_p = lock_ok & rx_data;
        dout_n = ~dout_p;
    end

    p_sd_gate_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !sd_s |=> !lock_ok);

    p_trk_gate_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !trk_s |=> !lock_ok);

    p_park_data_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !lock_ok |-> (!dout_p && dout_n));

endmodule

// File: tb/test_cdr_lock_ctrl.sv
`timescale 1ns/1fs
module test_cdr_lock_ctrl;

    localparam int WL  = 10;
    localparam int WIN = 1 << WL;

    logic ref_clk = 1'b0;
    logic osc_clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_present = 1'b1;
    logic track_en = 1'b1;
    logic rate_hi = 1'b0;
    logic bypass = 1'b0;
    logic rx_data = 1'b0;
    logic lock_ok, clk_out, dout_p, dout_n;

    real osc_half = 5.0 / 8.0;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    cdr_lock_ctrl #(.WIN_LOG2(WL), .LOW_RATIO(8), .PPM(500)) i_cdr_lock_ctrl (
        .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n),
        .sig_present(sig_present), .track_en(track_en), .rate_hi(rate_hi),
        .bypass(bypass), .rx_data(rx_data), .lock_ok(lock_ok),
        .clk_out(clk_out), .dout_p(dout_p), .dout_n(dout_n)
    );

    always #5 ref_clk = ~ref_clk;
    always begin
        #(osc_half);
        osc_clk = ~osc_clk;
    end

    typedef struct packed {
        logic               rate;
        logic [5:0]         mul;
        logic signed [15:0] ppm;
        logic               sd;
        logic               trk;
        logic               byp;
        logic               lk;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 6'd8,  16'sd0,     1'b1, 1'b1, 1'b0, 1'b1},  // R2 nominal
        '{1'b0, 6'd8,  16'sd300,   1'b1, 1'b1, 1'b0, 1'b1},  // R2 fast in tol
        '{1'b0, 6'd8,  -16'sd300,  1'b1, 1'b1, 1'b0, 1'b1},  // R2 slow in tol
        '{1'b0, 6'd8,  16'sd1500,  1'b1, 1'b1, 1'b0, 1'b0},  // R3 too fast
        '{1'b0, 6'd8,  -16'sd1500, 1'b1, 1'b1, 1'b0, 1'b0},  // R3 too slow
        '{1'b1, 6'd32, 16'sd0,     1'b1, 1'b1, 1'b0, 1'b1},  // R10 high rate
        '{1'b1, 6'd8,  16'sd0,     1'b1, 1'b1, 1'b0, 1'b0},  // R10 wrong ratio
        '{1'b0, 6'd8,  16'sd0,     1'b0, 1'b1, 1'b0, 1'b0},  // R5 loss of signal
        '{1'b0, 6'd8,  16'sd0,     1'b1, 1'b0, 1'b0, 1'b0},  // R6 forced to ref
        '{1'b0, 6'd8,  16'sd0,     1'b1, 1'b1, 1'b1, 1'b1}   // R11 bypass
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_osc(input int mul, input int ppm);
        osc_half = 5.0 / (real'(mul) * (1.0 + real'(ppm) * 1.0e-6));
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge ref_clk);
        #2;
    endtask

    // src: 0 = reference, 1 = oscillator, 2 = inverted reference
    task automatic chk_clk(input int src, input string req);
        if (src == 1) begin
            @(posedge osc_clk); #0.02;
            chk(clk_out == 1'b1, req, clk_out, 1);
            @(negedge osc_clk); #0.02;
            chk(clk_out == 1'b0, req, clk_out, 0);
        end else begin
            @(posedge ref_clk); #2;
            chk(clk_out == (src == 2 ? 1'b0 : 1'b1), req, clk_out, src == 2 ? 0 : 1);
            @(negedge ref_clk); #2;
            chk(clk_out == (src == 2 ? 1'b1 : 1'b0), req, clk_out, src == 2 ? 1 : 0);
        end
    endtask

    task automatic chk_data(input bit lk, input string req);
        rx_data = 1'b1; #1;
        chk(dout_p == lk && dout_n == !lk, req, {dout_p, dout_n}, {lk, !lk});
        rx_data = 1'b0; #1;
        chk(dout_p == 1'b0 && dout_n == 1'b1, req, {dout_p, dout_n}, 1);
    endtask

    initial begin
        set_osc(8, 0);
        // R1: reset state
        #23;
        chk(lock_ok == 1'b0, "R1 lock", lock_ok, 0);
        chk(dout_p == 1'b0 && dout_n == 1'b1, "R1 data", {dout_p, dout_n}, 1);
        @(negedge ref_clk); rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            rate_hi = TBL[i].rate;
            sig_present = TBL[i].sd;
            track_en = TBL[i].trk;
            bypass = TBL[i].byp;
            set_osc(int'(TBL[i].mul), int'(TBL[i].ppm));
            wait_cyc(5 * WIN);
            chk(lock_ok == TBL[i].lk, $sformatf("R2 R3 R10 R12 lock row %0d", i),
                lock_ok, TBL[i].lk);
            chk_data(TBL[i].lk, TBL[i].lk ? "R8 data pass" : "R7 data park");
            if (TBL[i].byp)      chk_clk(2, "R11 clock inverted ref");
            else if (TBL[i].lk)  chk_clk(1, "R8 clock from osc");
            else                 chk_clk(0, "R9 clock from ref");
        end
        bypass = 1'b0;

        // R4: hysteresis after reset with a good oscillator
        rst_n = 1'b0;
        set_osc(8, 0); rate_hi = 1'b0; sig_present = 1'b1; track_en = 1'b1;
        wait_cyc(4);
        @(negedge ref_clk); rst_n = 1'b1;
        wait_cyc(WIN * 5 / 2);
        chk(lock_ok == 1'b0, "R4 no lock after one measurement", lock_ok, 0);
        wait_cyc(WIN);
        chk(lock_ok == 1'b1, "R4 lock after two measurements", lock_ok, 1);

        // R5: signal-detect latency, three edges
        @(negedge ref_clk); sig_present = 1'b0;
        wait_cyc(2);
        chk(lock_ok == 1'b1, "R5 not before third edge", lock_ok, 1);
        wait_cyc(1);
        chk(lock_ok == 1'b0, "R5 low after third edge", lock_ok, 0);
        chk_data(1'b0, "R7 data park on loss of signal");
        @(negedge ref_clk); sig_present = 1'b1;
        wait_cyc(4);
        chk(lock_ok == 1'b1, "R5 lock returns", lock_ok, 1);

        // R6: track-enable latency
        @(negedge ref_clk); track_en = 1'b0;
        wait_cyc(3);
        chk(lock_ok == 1'b0, "R6 low after third edge", lock_ok, 0);
        chk_clk(0, "R9 clock follows ref when forced");
        @(negedge ref_clk); track_en = 1'b1;
        wait_cyc(4);
        chk(lock_ok == 1'b1, "R6 lock returns", lock_ok, 1);

        // R3: single bad measurement drops lock quickly
        set_osc(8, 1500);
        wait_cyc(2 * WIN + 20);
        chk(lock_ok == 1'b0, "R3 unlock within two windows", lock_ok, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge ref_clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule